// File: doc/BRIEF.md
# Command Mailbox Register Block

This block is the host-facing register window of a device command mailbox. A host reaches it over a little-endian register bus that carries 32-bit and 64-bit accesses. The window holds five registers. A capability register reports the payload size. A control register carries the doorbell. A command register holds the command, the command set and the payload length. A status register receives the return code, and a background-status register always reads zero.

The host loads the command register and then sets the doorbell. A two-state controller latches the command set and picks a return code. Because no command set is implemented, every command returns "unsupported". In the second cycle the controller writes the status register, clears the command register and drops the doorbell. The host polls the doorbell and reads the status register once the doorbell is clear.

The block checks the size and alignment of every access. It protects the registers the host may not write, and it freezes the command register while a command is in flight. Read data is returned combinationally in the cycle of the request.

Top module: `mbx_regblock`

## Requirements
- R1: After reset the capability register reads 0x0000000B: bits 4:0 hold the payload-size shift 11 (2048 bytes), bit 5 (interrupt support) and bit 6 (background support) are 0. The control, command, status and background-status registers read 0.
- R2: Only accesses of size 4 and 8 bytes are accepted. A read of any other size returns 0, and a write of any other size changes no register.
- R3: A 4-byte access at an address that is not a multiple of 4, or an 8-byte access at an address that is not a multiple of 8, is dropped. The read returns 0 and the write changes nothing.
- R4: The register map is: capability at 0x00, control at 0x04 (doorbell bit 0, background-interrupt enable bit 2), command at 0x08, status at 0x10 and background status at 0x18. A 64-bit read returns the register at the lower address in bits 31:0. A 32-bit read at an address with bit 2 set returns the upper half of its 8-byte slot.
- R5: In the command register, bits 7:0 are the command, bits 15:8 the command set and bits 35:16 the 20-bit payload length. Bits 63:36 always read 0. The register is writable as one 64-bit word or as either 32-bit half while no command is in flight.
- R6: Writes to the capability, status and background-status registers are ignored. Any 64-bit write at 0x00 is also ignored.
- R7: Writing 1 to control bit 0 sets the doorbell. Writing 0 there never clears it. Control bit 2 reads back the value last written. Other control bits read 0.
- R8: After the write that sets the doorbell, the doorbell reads 1 in the two following cycles and reads 0 from the third cycle on.
- R9: On completion the status register holds return code 0x3 (unsupported) in bits 47:32 and 0 in all other bits. This holds for every command-set value. The other codes are 0x0 success, 0x2 invalid input, 0x6 busy and 0x16 invalid payload length.
- R10: On completion the command and command-set fields are cleared and the length field holds the output length 0, so the command register reads 0.
- R11: While the doorbell is set, host writes to the command register are ignored. This includes a write in the completion cycle, where the controller's update takes effect. Host writes to the doorbell bit are also ignored while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | AW (5) | Byte offset into the window |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data, little-endian, 32-bit writes use bits 31:0 |
| bus_rdata | output | 64 | Read data for the current request, 0 when rejected |

## Verification
Two events can fall in the same cycle: the controller's completion write to the command register and a host write to that register. The bench rings the doorbell and then issues back-to-back 64-bit command writes, one landing in the decode cycle and one in the completion cycle. It expects the first write to leave the earlier value in place and the second to leave the register at zero. A host write of 0 to the doorbell during the decode cycle is also issued, and the doorbell must still read 1 until completion.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [15:0] {
    RC_SUCCESS     = 16'h0000,
    RC_INVALID     = 16'h0002,
    RC_UNSUPPORTED = 16'h0003,
    RC_BUSY        = 16'h0006,
    RC_BAD_LENGTH  = 16'h0016
  } rc_e;

  typedef enum logic [0:0] {
    SQ_IDLE   = 1'b0,
    SQ_DECODE = 1'b1
  } sq_e;

  // Return code picked for a command set; no set is implemented.
  function automatic rc_e pick_rc(input logic [7:0] cmd_set);
    rc_e rc;
    case (cmd_set)
      default: rc = RC_UNSUPPORTED;
    endcase
    return rc;
  endfunction

  // Capability word: payload shift in bits 4:0, no irq (5), no background (6).
  function automatic logic [31:0] cap_word(input int unsigned shift);
    logic [31:0] w;
    w = '0;
    w[4:0] = shift[4:0];
    return w;
  endfunction

  // Status word: return code in bits 47:32, everything else zero.
  function automatic logic [63:0] status_word(input logic [15:0] code);
    return {16'h0000, code, 32'h0000_0000};
  endfunction

  // Command word after completion: length field only.
  function automatic logic [63:0] done_cmd_word(input logic [31:0] out_len);
    return 64'(out_len) << 16;
  endfunction

  // Narrow a 64-bit slot to the access size.
  function automatic logic [63:0] size_select(input logic [63:0] q,
                                              input logic is64,
                                              input logic hi);
    if (is64) return q;
    return hi ? {32'h0, q[63:32]} : {32'h0, q[31:0]};
  endfunction

endpackage

// File: rtl/mbx_access_check.sv
module mbx_access_check #(
  parameter int AW = 5
) (
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    size,
  output logic          acc_ok,
  output logic          rd_ok,
  output logic          wr_ok,
  output logic          is64,
  output logic          hi,
  output logic [AW-4:0] qidx
);
  logic size4, size8, al4, al8;

  always_comb begin
    size4  = (size == 4'd4);
    size8  = (size == 4'd8);
    al4    = (addr[1:0] == 2'b00);
    al8    = (addr[2:0] == 3'b000);
    acc_ok = valid && ((size4 && al4) || (size8 && al8));
    rd_ok  = acc_ok && !write;
    wr_ok  = acc_ok && write;
    is64   = size8;
    hi     = addr[2];
    qidx   = addr[AW-1:3];
  end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ring,
  input  logic [7:0]  cmd_set,
  output logic        done,
  output logic [15:0] ret
);
  sq_e  state_q;
  rc_e  rc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rc_q    <= RC_SUCCESS;
    end else begin
      case (state_q)
        SQ_IDLE: if (ring) begin
          state_q <= SQ_DECODE;
          rc_q    <= pick_rc(cmd_set);
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign done = (state_q == SQ_DECODE);
  assign ret  = rc_q;
endmodule

// File: rtl/mbx_regblock.sv
module mbx_regblock
  import mbx_pkg::*;
#(
  parameter int AW            = 5,
  parameter int PAYLOAD_SHIFT = 11,
  parameter int LEN_W         = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_size,
  input  logic [63:0]   bus_wdata,
  output logic [63:0]   bus_rdata
);
  localparam int CMD_W = 16 + LEN_W;
  localparam int QW    = AW - 3;
  localparam int HI_W  = CMD_W - 32;

  logic          acc_ok, rd_ok, wr_ok, is64, hi;
  logic [QW-1:0] qidx;

  logic             db_q, bgie_q;
  logic [CMD_W-1:0] cmd_q;
  logic [15:0]      sts_code_q;
  logic             seq_done;
  logic [15:0]      seq_ret;

  logic        ctrl_we, cmd_lo_we, cmd_hi_we;
  logic [31:0] hi_data;
  logic [31:0] ctrl_word;
  logic [63:0] slot;
  logic        unused_hi;

  mbx_access_check #(.AW(AW)) u_acc (
    .valid (bus_valid),
    .write (bus_write),
    .addr  (bus_addr),
    .size  (bus_size),
    .acc_ok(acc_ok),
    .rd_ok (rd_ok),
    .wr_ok (wr_ok),
    .is64  (is64),
    .hi    (hi),
    .qidx  (qidx)
  );

  mbx_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ring   (db_q),
    .cmd_set(cmd_q[15:8]),
    .done   (seq_done),
    .ret    (seq_ret)
  );

  // Write decode
  always_comb begin
    ctrl_we   = wr_ok && !is64 && hi && (qidx == QW'(0));
    cmd_lo_we = wr_ok && (qidx == QW'(1)) && (is64 || !hi);
    cmd_hi_we = wr_ok && (qidx == QW'(1)) && (is64 || hi);
    hi_data   = is64 ? bus_wdata[63:32] : bus_wdata[31:0];
  end

  assign unused_hi = ^hi_data[31:HI_W];

  // Doorbell and control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q   <= 1'b0;
      bgie_q <= 1'b0;
    end else begin
      if (ctrl_we) bgie_q <= bus_wdata[2];
      if (seq_done)                           db_q <= 1'b0;
      else if (ctrl_we && bus_wdata[0] && !db_q) db_q <= 1'b1;
    end
  end

  // Command register: controller has priority, host locked while ringing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (seq_done) begin
      cmd_q <= CMD_W'(done_cmd_word(32'h0));
    end else if (!db_q) begin
      if (cmd_lo_we) cmd_q[31:0]      <= bus_wdata[31:0];
      if (cmd_hi_we) cmd_q[CMD_W-1:32] <= hi_data[HI_W-1:0];
    end
  end

  // Status register: written only by the controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sts_code_q <= '0;
    else if (seq_done) sts_code_q <= seq_ret;
  end

  // Read path
  always_comb begin
    ctrl_word = {29'h0, bgie_q, 1'b0, db_q};
    case (qidx)
      QW'(0):  slot = {ctrl_word, cap_word(PAYLOAD_SHIFT)};
      QW'(1):  slot = 64'(cmd_q);
      QW'(2):  slot = status_word(sts_code_q);
      default: slot = '0;
    endcase
    bus_rdata = rd_ok ? size_select(slot, is64, hi) : 64'h0;
  end

endmodule

// File: rtl/mbx_checks.sv
module mbx_checks #(
  parameter int CMD_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             acc_ok,
  input logic [63:0]      bus_rdata,
  input logic             db,
  input logic             seq_done,
  input logic [15:0]      seq_ret,
  input logic [CMD_W-1:0] cmd,
  input logic [15:0]      sts_code
);
  // R2 and R3: a rejected read returns zero
  p_reject_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !acc_ok) |-> (bus_rdata == 64'h0));

  p_ring_to_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db) |=> seq_done);

  p_done_drops_bell_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !db);

  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  p_status_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (sts_code == 16'h0003));

  p_ret_unsupported_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (seq_ret == 16'h0003));

  p_cmd_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (cmd == '0));

  p_cmd_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (db && !seq_done) |=> $stable(cmd));

  p_status_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> $stable(sts_code));
endmodule

bind mbx_regblock mbx_checks #(.CMD_W(CMD_W)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .acc_ok   (acc_ok),
  .bus_rdata(bus_rdata),
  .db       (db_q),
  .seq_done (seq_done),
  .seq_ret  (seq_ret),
  .cmd      (cmd_q),
  .sts_code (sts_code_q)
);

// File: tb/mbx_regblock_test.sv
module mbx_regblock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model of the register contents
  logic [31:0] m_cap  = 32'h0000_000B;
  logic [31:0] m_ctrl = 32'h0;
  logic [63:0] m_cmd  = 64'h0;
  logic [63:0] m_sts  = 64'h0;

  always #5 clk = ~clk;

  mbx_regblock uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic bit legal(input int a, input int s);
    return (s == 4 && a % 4 == 0) || (s == 8 && a % 8 == 0);
  endfunction

  function automatic logic [63:0] exp_rd(input int a, input int s);
    logic [63:0] q;
    if (!legal(a, s)) return 64'h0;
    case (a / 8)
      0: q = {m_ctrl, m_cap};
      1: q = m_cmd;
      2: q = m_sts;
      default: q = 64'h0;
    endcase
    if (s == 8) return q;
    return (a % 8 == 4) ? {32'h0, q[63:32]} : {32'h0, q[31:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input int s, output logic [63:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'(a); bus_size = 4'(s);
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic rd_check(input string tag, input int a, input int s, input logic [63:0] exp);
    logic [63:0] d;
    rd(a, s, d);
    check(tag, d, exp);
  endtask

  task automatic wr(input int a, input int s, input logic [63:0] data);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'(a); bus_size = 4'(s);
    bus_wdata = data;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_map(input string tag);
    for (int a = 0; a < 32; a += 4) rd_check(tag, a, 4, exp_rd(a, 4));
    for (int a = 0; a < 32; a += 8) rd_check(tag, a, 8, exp_rd(a, 8));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2, R3: full read sweep of the reset state
    for (int a = 0; a < 32; a++)
      for (int s = 0; s < 16; s++) begin
        string tag;
        tag = (s != 4 && s != 8) ? "R2" : (!legal(a, s) ? "R3" : "R1");
        rd_check(tag, a, s, exp_rd(a, s));
      end

    // R7 / R4: control bit 2 read back, packing of a 64-bit read at 0x0
    wr(4, 4, 64'h4); m_ctrl = 32'h4;
    rd_check("R7", 4, 4, 64'h4);
    check_map("R4");
    rd_check("R4", 0, 8, 64'h0000_0004_0000_000B);
    wr(4, 4, 64'h0); m_ctrl = 32'h0;
    rd_check("R7", 4, 4, 64'h0);

    // R5: field layout and width of the command register
    wr(8, 8, 64'hFFFF_FFFF_FFFF_FFFF); m_cmd = 64'h0000_000F_FFFF_FFFF;
    rd_check("R5", 8, 8, m_cmd);
    wr(8, 8, 64'h0000_000A_BCDE_3412); m_cmd = 64'h0000_000A_BCDE_3412;
    rd_check("R5", 8, 4, 64'hBCDE_3412);
    rd_check("R5", 12, 4, 64'hA);
    wr(12, 4, 64'h5); m_cmd = 64'h0000_0005_BCDE_3412;
    rd_check("R5", 8, 8, m_cmd);
    wr(8, 4, 64'h1111_2222); m_cmd = 64'h0000_0005_1111_2222;
    rd_check("R5", 8, 8, m_cmd);

    // R8, R9, R10: doorbell timing and completion contents
    wr(4, 4, 64'h1);
    rd_check("R8", 4, 4, 64'h1);
    tick();
    rd_check("R8", 4, 4, 64'h1);
    tick();
    rd_check("R8", 4, 4, 64'h0);
    m_sts = 64'h0000_0003_0000_0000; m_cmd = 64'h0;
    rd_check("R9", 16, 8, m_sts);
    rd_check("R9", 20, 4, 64'h3);
    rd_check("R10", 8, 8, 64'h0);

    // R6: protected registers ignore host writes
    wr(0, 4, '1);
    wr(0, 8, '1);
    wr(16, 8, 64'h0);
    wr(16, 4, '1);
    wr(20, 4, 64'h0);
    wr(24, 8, '1);
    wr(28, 4, '1);
    check_map("R6");

    // R11: command writes during decode and completion cycles
    wr(8, 8, 64'h0000_0001_2345_6789); m_cmd = 64'h0000_0001_2345_6789;
    wr(4, 4, 64'h1);
    wr(8, 8, 64'h0000_0007_7777_7777);
    rd_check("R11", 8, 8, 64'h0000_0001_2345_6789);
    wr(8, 8, 64'h0000_0007_7777_7777);
    rd_check("R11", 8, 8, 64'h0);
    rd_check("R11", 4, 4, 64'h0);
    m_cmd = 64'h0;

    // R11 / R7: doorbell cannot be cleared by the host
    wr(4, 4, 64'h1);
    wr(4, 4, 64'h0);
    rd_check("R11", 4, 4, 64'h1);
    tick();
    rd_check("R8", 4, 4, 64'h0);

    // R9, R10 across several command-set values
    for (int i = 0; i < 8; i++) begin
      logic [63:0] c;
      c = (64'(i + 1) << 16) | (64'((i * 37) & 8'hFF) << 8) | 64'(i);
      wr(8, 8, c);
      rd_check("R5", 8, 8, c);
      wr(4, 4, 64'h1);
      tick();
      tick();
      rd_check("R9", 16, 8, 64'h0000_0003_0000_0000);
      rd_check("R10", 8, 8, 64'h0);
    end

    // R2: writes of illegal size change nothing
    wr(8, 8, 64'h0000_0002_4680_1357); m_cmd = 64'h0000_0002_4680_1357;
    for (int a = 0; a < 32; a++)
      for (int s = 0; s < 16; s++)
        if (s != 4 && s != 8) wr(a, s, '1);
    check_map("R2");

    // R3: misaligned writes change nothing
    for (int a = 0; a < 32; a++)
      for (int s = 4; s <= 8; s += 4)
        if (!legal(a, s)) wr(a, s, '1);
    check_map("R3");
    rd_check("R3", 4, 4, 64'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule